// File: doc/BRIEF.md
# Blink Phase Timer

This block produces the slow alternating phase used for blinking text cells and for flipping between two display pages in bitmap modes. One byte written to its period register carries two independent 4-bit durations: an on-time in the upper nibble and an off-time in the lower nibble. Each duration is counted in steps of `STEP_FRAMES` vertical frames, with a default of 10. The timer advances once for each frame tick and toggles its phase bit when the current duration runs out.

The phase also selects the colors for the current cell. When the cell is marked blinking and the phase is alternate, the alternate color pair is output. In every other case the normal pair is output. In bitmap modes the phase output is used directly as the page select.

Writing the period register restarts the sequence. A duration of zero removes that phase from the cycle.

Top module: `blink_timer`

## Requirements
- R1: A period write latches bits 7:4 of `period_data` as the on code and bits 3:0 as the off code.
- R2: With both codes non-zero, the alternate phase (`blink_phase`=1) lasts on×`STEP_FRAMES` frame ticks and the normal phase (`blink_phase`=0) lasts off×`STEP_FRAMES` frame ticks. The two phases alternate indefinitely.
- R3: After a period write, the next cycle shows phase 1 with a full on-time count if the on code is non-zero. If the on code is zero, it shows phase 0 with a full off-time count.
- R4: When both codes are zero, `blink_phase` is 0 and stays 0 across frame ticks.
- R5: When exactly one code is zero, the phase belonging to the non-zero code holds permanently.
- R6: `blink_phase` changes only on a clock edge where `frame_tick` or `period_wr` is high.
- R7: One cycle after the inputs, `fg_out`/`bg_out` equal `alt_color[7:4]`/`alt_color[3:0]` when `cell_blink` and `blink_phase` are both 1. Otherwise they equal `norm_fg`/`norm_bg`.
- R8: After synchronous reset, both codes are 0, `blink_phase` is 0, and `fg_out`/`bg_out` are 0.
- R9: A period write takes priority over a frame tick in the same cycle. The tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per vertical frame |
| period_wr | input | 1 | Period register write strobe |
| period_data | input | 8 | On code [7:4], off code [3:0] |
| cell_blink | input | 1 | Current cell carries the blink attribute |
| norm_fg | input | 4 | Normal foreground color code |
| norm_bg | input | 4 | Normal background color code |
| alt_color | input | 8 | Alternate foreground [7:4], background [3:0] |
| blink_phase | output | 1 | 1 = alternate phase / second page |
| fg_out | output | 4 | Selected foreground color code |
| bg_out | output | 4 | Selected background color code |

## Verification
The main timing is exercised with several period bytes:
- Asymmetric codes such as 0x21 and 0x13 tell a swapped nibble order apart from the correct one and show that each phase gets its own length.
- The equal pair 0x11 checks the basic alternation.
- The single-zero bytes 0x30 and 0x02 separate "stay in the other phase" from "toggle every tick".
- The byte 0x00 shows that the timer is parked.

For each byte, the phase is compared after every frame tick over two periods against a closed-form expectation. Directed cases then cover a rewrite in the middle of a phase, a write and a tick in the same cycle, phase stability without ticks, and the color selection for blinking and non-blinking cells.

// File: rtl/blink_pkg.sv
package blink_pkg;
  function automatic int unsigned phase_len(input int unsigned code, input int unsigned step);
    return code * step;
  endfunction
endpackage

// File: rtl/blink_period_reg.sv
module blink_period_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2*CODE_W-1:0] data,
  output logic [CODE_W-1:0] on_code,
  output logic [CODE_W-1:0] off_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      on_code  <= '0;
      off_code <= '0;
    end else if (wr) begin
      on_code  <= data[2*CODE_W-1:CODE_W];
      off_code <= data[CODE_W-1:0];
    end
  end

  assert_field_split_R1: assert property (@(posedge clk) disable iff (rst)
    wr |=> (on_code == $past(data[2*CODE_W-1:CODE_W]) && off_code == $past(data[CODE_W-1:0])));
endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer
  import blink_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int STEP_FRAMES = 10,
  parameter int CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr,
  input  logic [2*CODE_W-1:0] wr_data,
  input  logic [CODE_W-1:0]   on_code,
  input  logic [CODE_W-1:0]   off_code,
  output logic                phase
);
  logic [CNT_W-1:0]  remain;
  logic [CODE_W-1:0] new_on, new_off, next_code;
  logic              next_phase;

  assign new_on  = wr_data[2*CODE_W-1:CODE_W];
  assign new_off = wr_data[CODE_W-1:0];

  always_comb begin
    next_phase = !phase;
    next_code  = phase ? off_code : on_code;
    if (next_code == '0) begin
      next_phase = phase;
      next_code  = phase ? on_code : off_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      remain <= '0;
    end else if (wr) begin
      if (new_on != '0) begin
        phase  <= 1'b1;
        remain <= CNT_W'(phase_len(new_on, STEP_FRAMES));
      end else begin
        phase  <= 1'b0;
        remain <= CNT_W'(phase_len(new_off, STEP_FRAMES));
      end
    end else if (tick && (on_code != '0 || off_code != '0)) begin
      if (remain <= CNT_W'(1)) begin
        phase  <= next_phase;
        remain <= CNT_W'(phase_len(next_code, STEP_FRAMES));
      end else begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assert_parked_R4: assert property (@(posedge clk) disable iff (rst)
    (on_code == '0 && off_code == '0) |-> !phase);
  assert_restart_on_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && new_on != '0) |=> phase);
  assert_restart_off_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && new_on == '0) |=> !phase);
  assert_hold_on_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr && off_code == '0 && on_code != '0 && phase) |=> phase);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr && !tick) |=> $stable(phase));
endmodule

// File: rtl/blink_color_sel.sv
module blink_color_sel #(
  parameter int COLOR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phase,
  input  logic                 cell_blink,
  input  logic [COLOR_W-1:0]   norm_fg,
  input  logic [COLOR_W-1:0]   norm_bg,
  input  logic [2*COLOR_W-1:0] alt_color,
  output logic [COLOR_W-1:0]   fg_out,
  output logic [COLOR_W-1:0]   bg_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fg_out <= '0;
      bg_out <= '0;
    end else if (cell_blink && phase) begin
      fg_out <= alt_color[2*COLOR_W-1:COLOR_W];
      bg_out <= alt_color[COLOR_W-1:0];
    end else begin
      fg_out <= norm_fg;
      bg_out <= norm_bg;
    end
  end

  assert_plain_cell_R7: assert property (@(posedge clk) disable iff (rst)
    !cell_blink |=> (fg_out == $past(norm_fg) && bg_out == $past(norm_bg)));
endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int CODE_W      = 4,
  parameter int COLOR_W     = 4,
  parameter int STEP_FRAMES = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_tick,
  input  logic                 period_wr,
  input  logic [2*CODE_W-1:0]  period_data,
  input  logic                 cell_blink,
  input  logic [COLOR_W-1:0]   norm_fg,
  input  logic [COLOR_W-1:0]   norm_bg,
  input  logic [2*COLOR_W-1:0] alt_color,
  output logic                 blink_phase,
  output logic [COLOR_W-1:0]   fg_out,
  output logic [COLOR_W-1:0]   bg_out
);
  localparam int MAX_LEN = STEP_FRAMES * ((1 << CODE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CODE_W-1:0] on_code, off_code;

  blink_period_reg #(.CODE_W(CODE_W)) u_reg (
    .clk(clk), .rst(rst), .wr(period_wr), .data(period_data),
    .on_code(on_code), .off_code(off_code));

  blink_sequencer #(.CODE_W(CODE_W), .STEP_FRAMES(STEP_FRAMES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .tick(frame_tick), .wr(period_wr), .wr_data(period_data),
    .on_code(on_code), .off_code(off_code), .phase(blink_phase));

  blink_color_sel #(.COLOR_W(COLOR_W)) u_col (
    .clk(clk), .rst(rst), .phase(blink_phase), .cell_blink(cell_blink),
    .norm_fg(norm_fg), .norm_bg(norm_bg), .alt_color(alt_color),
    .fg_out(fg_out), .bg_out(bg_out));
endmodule

// File: tb/blink_timer_tb.sv
module blink_timer_tb;
  localparam int STEP = 10;
  logic clk = 1'b0;
  logic rst, frame_tick, period_wr, cell_blink;
  logic [7:0] period_data, alt_color;
  logic [3:0] norm_fg, norm_bg, fg_out, bg_out;
  logic blink_phase;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blink_timer #(.STEP_FRAMES(STEP)) u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .period_wr(period_wr),
    .period_data(period_data), .cell_blink(cell_blink), .norm_fg(norm_fg),
    .norm_bg(norm_bg), .alt_color(alt_color), .blink_phase(blink_phase),
    .fg_out(fg_out), .bg_out(bg_out));

  // Vectors: {expected phase right after write, period byte}
  localparam logic [8:0] VEC [6] = '{9'h121, 9'h113, 9'h111, 9'h130, 9'h002, 9'h000};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic tick();
    frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d, input logic with_tick);
    period_wr = 1'b1; period_data = d; frame_tick = with_tick;
    @(negedge clk);
    period_wr = 1'b0; frame_tick = 1'b0;
  endtask

  function automatic int model(input int on, input int off, input int k);
    if (on == 0) return 0;
    if (off == 0) return 1;
    return ((k % ((on + off) * STEP)) < on * STEP) ? 1 : 0;
  endfunction

  initial begin
    while (!done && cycles < 200000) begin @(posedge clk); cycles++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; frame_tick = 0; period_wr = 0; period_data = 0;
    cell_blink = 0; norm_fg = 4'h3; norm_bg = 4'hC; alt_color = 8'hA5;
    repeat (3) idle();
    rst = 0;
    // R8: reset state
    check("R8 phase", blink_phase, 0);
    check("R8 fg", fg_out, 0);
    check("R8 bg", bg_out, 0);
    idle();
    // R4: never written, ticks do nothing
    repeat (25) tick();
    check("R4 unwritten", blink_phase, 0);

    // R1 R2 R3 R4 R5: table walk
    foreach (VEC[i]) begin
      int on, off, span;
      on = int'(VEC[i][7:4]); off = int'(VEC[i][3:0]);
      write(VEC[i][7:0], 1'b0);
      check("R3 start", blink_phase, int'(VEC[i][8]));
      span = (on + off) * STEP * 2;
      if (span == 0) span = 30;
      if (span > 90) span = 90;
      for (int k = 1; k <= span; k++) begin
        tick();
        check((on == 0 || off == 0) ? "R5/R4 hold" : "R1/R2 timing", blink_phase, model(on, off, k));
      end
    end

    // R3: rewrite mid-phase restarts full on count
    write(8'h12, 1'b0);
    repeat (7) tick();
    write(8'h12, 1'b0);
    repeat (9) tick();
    check("R3 restart mid", blink_phase, 1);
    tick();
    check("R3 restart end", blink_phase, 0);

    // R6: no ticks, no change
    repeat (40) idle();
    check("R6 stable", blink_phase, 0);

    // R9: write with simultaneous tick, tick ignored
    write(8'h11, 1'b1);
    repeat (9) tick();
    check("R9 tick ignored", blink_phase, 1);
    tick();
    check("R9 boundary", blink_phase, 0);

    // R7: color selection
    write(8'h11, 1'b0);
    cell_blink = 1; idle();
    check("R7 alt fg", fg_out, 4'hA);
    check("R7 alt bg", bg_out, 4'h5);
    cell_blink = 0; idle();
    check("R7 plain fg", fg_out, 4'h3);
    check("R7 plain bg", bg_out, 4'hC);
    cell_blink = 1;
    repeat (10) tick();
    idle();
    check("R7 off phase fg", fg_out, 4'h3);
    check("R7 off phase bg", bg_out, 4'hC);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule